// File: doc/BRIEF.md
# Prioritized Reply Byte Source

This block hands reply bytes to a serial slave engine. Each time the engine reaches a byte boundary it raises a one-cycle request. The block answers on the next cycle with one byte and a valid flag, or with a no-reply flag when it has nothing to send.

The byte can come from three places, checked in a fixed order:

1. A small ring FIFO that host logic fills.
2. A one-time forced byte that the engine's start-up sequence arms.
3. A staged fallback byte that the host can load at any time.

The forced and staged sources are each cleared when they are used. When the ring is full, the block either overwrites the oldest entry or refuses the write, depending on a build-time choice.

Saturating counters record how requests were served. A one-cycle strobe clears them. The current ring occupancy is also reported.

Top module: `reply_source_arbiter`

## Requirements
- R1: After a synchronous reset, the following hold:
  - `rply_valid` and `rply_none` are low, `fifo_level` is 0, `host_full` is low and every counter reads 0.
  - The staged byte holds 0x01 and is armed.
  - The forced byte is disarmed.
- R2: A request made while the ring holds data returns the oldest ring byte. The answer appears on `rply_valid`/`rply_data` in the cycle after the request, and bytes leave the ring in the order they were written.
- R3: A request made while the ring is empty and the forced byte is armed returns the forced byte and disarms it.
- R4: A request made while the ring is empty and the forced byte is disarmed returns the staged byte if it is armed, and disarms it. Pulsing `stage_load` writes the byte and arms it on the same clock edge.
- R5: A request with no armed source raises `rply_none` for one cycle, with `rply_valid` low.
- R6: With `OVERWRITE`=1, a write into a full ring drops the oldest entry and keeps the newest `DEPTH` bytes. `host_full` is high while the ring holds `DEPTH` bytes, and the write adds one to `cnt_ovwr`.
- R7: With `OVERWRITE`=0, a write into a full ring with no read in that cycle is refused, and the stored bytes are unchanged.
- R8: A host write and a request in the same cycle on an empty ring do not return the new byte to that request. The byte is returned to the next request.
- R9: The counters count as follows:
  - `cnt_total` counts every byte supplied.
  - `cnt_fifo` counts bytes taken from the ring.
  - `cnt_fallback` counts bytes taken from the forced or staged source.
  - `cnt_none` counts requests that got no reply.
  - `fifo_level` reports the current ring occupancy.
- R10: Each counter stops at its maximum value. A one-cycle `stat_clr` sets every counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe into the ring |
| host_wr_data | input | DATA_W | Byte to enqueue |
| host_full | output | 1 | Ring holds DEPTH bytes |
| force_arm | input | 1 | Load and arm the forced byte |
| force_data | input | DATA_W | Forced byte value |
| stage_load | input | 1 | Load and arm the staged byte |
| stage_data | input | DATA_W | Staged byte value |
| eng_req | input | 1 | Engine request at a byte boundary |
| rply_valid | output | 1 | Registered: reply byte present |
| rply_none | output | 1 | Registered: request had no reply |
| rply_data | output | DATA_W | Registered reply byte |
| stat_clr | input | 1 | Clear all counters |
| cnt_total | output | CNT_W | Bytes supplied |
| cnt_fifo | output | CNT_W | Bytes taken from the ring |
| cnt_fallback | output | CNT_W | Bytes from the forced or staged source |
| cnt_none | output | CNT_W | Requests with no reply |
| cnt_ovwr | output | CNT_W | Ring overwrites |
| fifo_level | output | $clog2(DEPTH)+1 | Current ring occupancy |

## Verification
Two situations are hard to reach from the ports:

- **Full ring.** A write that arrives while the ring is full behaves differently under the overwrite and refuse policies. The bench drives two instances from the same stimulus: the default build, and one with a smaller ring, the refuse policy and narrow counters. It writes more bytes than either ring holds, then drains both and compares what comes out.
- **Saturation.** Reaching a counter's maximum needs many requests. The narrow counters of the second instance reach it after a handful of empty requests.

The same-cycle write-and-request case on an empty ring is driven directly in a single cycle.

// File: rtl/rsrc_pkg.sv
package rsrc_pkg;

  // Which source served a request (SRC_NONE: no request, or nothing armed)
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_FIFO  = 2'd1,
    SRC_FORCE = 2'd2,
    SRC_STAGE = 2'd3
  } src_e;

  // Counter slots in the statistics block
  localparam int unsigned CNT_TOTAL    = 0;
  localparam int unsigned CNT_FIFO     = 1;
  localparam int unsigned CNT_FALLBACK = 2;
  localparam int unsigned CNT_NONE     = 3;
  localparam int unsigned CNT_OVWR     = 4;
  localparam int unsigned NUM_CNT      = 5;

endpackage

// File: rtl/rsrc_ring.sv
module rsrc_ring #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DEPTH     = 8,
  parameter bit          OVERWRITE = 1'b1,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned LW       = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [LW-1:0]     level,
  output logic              ovwr
);

  // Pointers are one bit wider than the address so full and empty differ
  logic [AW:0]       wp, rp;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              accept;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign level = wp - rp;
  assign head  = mem[rp[AW-1:0]];

  // The full-ring policy is picked at build time
  generate
    if (OVERWRITE) begin : g_ovw
      assign accept = wr_en;
      assign ovwr   = wr_en && full && !pop;
    end else begin : g_refuse
      assign accept = wr_en && (!full || pop);
      assign ovwr   = 1'b0;

      // R7
      refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !pop) |=> $stable(wp) && full);
    end
  endgenerate

  // Storage without reset, one write port: maps onto a RAM
  always_ff @(posedge clk) begin
    if (accept) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (accept)      wp <= wp + 1'b1;
      if (pop || ovwr) rp <= rp + 1'b1;
    end
  end

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R2
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R6
  ovwr_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    ovwr |=> full);

endmodule

// File: rtl/rsrc_select.sv
module rsrc_select
  import rsrc_pkg::*;
#(
  parameter int unsigned        DATA_W     = 8,
  parameter logic [DATA_W-1:0]  STAGE_INIT = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              force_arm,
  input  logic [DATA_W-1:0] force_data,
  input  logic              stage_load,
  input  logic [DATA_W-1:0] stage_data,
  output logic              pop,
  output src_e              src,
  output logic              rply_valid,
  output logic              rply_none,
  output logic [DATA_W-1:0] rply_data
);

  logic [DATA_W-1:0] force_q, stage_q;
  logic              force_armed, stage_armed;

  // Fixed order: ring, forced one-shot, staged fallback
  always_comb begin
    src = SRC_NONE;
    if (req) begin
      if (!fifo_empty)      src = SRC_FIFO;
      else if (force_armed) src = SRC_FORCE;
      else if (stage_armed) src = SRC_STAGE;
    end
  end

  assign pop = (src == SRC_FIFO);

  // A fresh load wins over a same-cycle consume
  always_ff @(posedge clk) begin
    if (rst) begin
      force_q     <= '0;
      force_armed <= 1'b0;
    end else if (force_arm) begin
      force_q     <= force_data;
      force_armed <= 1'b1;
    end else if (src == SRC_FORCE) begin
      force_armed <= 1'b0;
    end
  end

  // Data and arm flag change on the same edge: never torn
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q     <= STAGE_INIT;
      stage_armed <= 1'b1;
    end else if (stage_load) begin
      stage_q     <= stage_data;
      stage_armed <= 1'b1;
    end else if (src == SRC_STAGE) begin
      stage_armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rply_valid <= 1'b0;
      rply_none  <= 1'b0;
      rply_data  <= '0;
    end else begin
      rply_valid <= (src != SRC_NONE);
      rply_none  <= req && (src == SRC_NONE);
      unique case (src)
        SRC_FIFO:  rply_data <= fifo_head;
        SRC_FORCE: rply_data <= force_q;
        SRC_STAGE: rply_data <= stage_q;
        default:   rply_data <= rply_data;
      endcase
    end
  end

  // R5
  valid_none_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rply_valid && rply_none));

  // R2
  fifo_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !fifo_empty) |=> rply_valid && (rply_data == $past(fifo_head)));

  // R3
  force_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (req && fifo_empty && force_armed && !force_arm) |=> !force_armed);

  // R4
  stage_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (req && fifo_empty && !force_armed && stage_armed && !stage_load)
      |=> !stage_armed);

  // R4
  stage_load_arm_chk: assert property (@(posedge clk) disable iff (rst)
    stage_load |=> stage_armed && (stage_q == $past(stage_data)));

endmodule

// File: rtl/rsrc_stats.sv
module rsrc_stats
  import rsrc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic                            req,
  input  src_e                            src,
  input  logic                            ovwr,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CNT-1:0] inc;

  always_comb begin
    inc               = '0;
    inc[CNT_TOTAL]    = (src != SRC_NONE);
    inc[CNT_FIFO]     = (src == SRC_FIFO);
    inc[CNT_FALLBACK] = (src == SRC_FORCE) || (src == SRC_STAGE);
    inc[CNT_NONE]     = req && (src == SRC_NONE);
    inc[CNT_OVWR]     = ovwr;
  end

  // One saturating counter per slot
  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst || clr)                      cnt[g] <= '0;
        else if (inc[g] && cnt[g] != CNT_MAX) cnt[g] <= cnt[g] + 1'b1;
      end

      // R10
      sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt[g] == CNT_MAX && !clr) |=> cnt[g] == CNT_MAX);

      // R10
      clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt[g] == '0);
    end
  endgenerate

endmodule

// File: rtl/reply_source_arbiter.sv
module reply_source_arbiter
  import rsrc_pkg::*;
#(
  parameter int unsigned       DATA_W     = 8,
  parameter int unsigned       DEPTH      = 8,
  parameter bit                OVERWRITE  = 1'b1,
  parameter int unsigned       CNT_W      = 16,
  parameter logic [DATA_W-1:0] STAGE_INIT = 8'h01,
  localparam int unsigned      LW         = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic              host_full,
  input  logic              force_arm,
  input  logic [DATA_W-1:0] force_data,
  input  logic              stage_load,
  input  logic [DATA_W-1:0] stage_data,
  input  logic              eng_req,
  output logic              rply_valid,
  output logic              rply_none,
  output logic [DATA_W-1:0] rply_data,
  input  logic              stat_clr,
  output logic [CNT_W-1:0]  cnt_total,
  output logic [CNT_W-1:0]  cnt_fifo,
  output logic [CNT_W-1:0]  cnt_fallback,
  output logic [CNT_W-1:0]  cnt_none,
  output logic [CNT_W-1:0]  cnt_ovwr,
  output logic [LW-1:0]     fifo_level
);

  logic                          pop, empty, ovwr;
  logic [DATA_W-1:0]             head;
  src_e                          src;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  rsrc_ring #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .OVERWRITE (OVERWRITE)
  ) ring_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (host_wr_en),
    .wr_data (host_wr_data),
    .pop     (pop),
    .head    (head),
    .empty   (empty),
    .full    (host_full),
    .level   (fifo_level),
    .ovwr    (ovwr)
  );

  rsrc_select #(
    .DATA_W     (DATA_W),
    .STAGE_INIT (STAGE_INIT)
  ) sel_i (
    .clk        (clk),
    .rst        (rst),
    .req        (eng_req),
    .fifo_empty (empty),
    .fifo_head  (head),
    .force_arm  (force_arm),
    .force_data (force_data),
    .stage_load (stage_load),
    .stage_data (stage_data),
    .pop        (pop),
    .src        (src),
    .rply_valid (rply_valid),
    .rply_none  (rply_none),
    .rply_data  (rply_data)
  );

  rsrc_stats #(
    .CNT_W (CNT_W)
  ) stats_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (stat_clr),
    .req  (eng_req),
    .src  (src),
    .ovwr (ovwr),
    .cnt  (cnt)
  );

  assign cnt_total    = cnt[CNT_TOTAL];
  assign cnt_fifo     = cnt[CNT_FIFO];
  assign cnt_fallback = cnt[CNT_FALLBACK];
  assign cnt_none     = cnt[CNT_NONE];
  assign cnt_ovwr     = cnt[CNT_OVWR];

  // R9
  total_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (rply_valid && !$past(stat_clr)) |-> cnt_total != '0);

endmodule

// File: tb/reply_source_arbiter_tb.sv
`timescale 1ns/1ps
module reply_source_arbiter_tb_top;

  localparam logic [1:0] OP_REQ = 2'd0, OP_PUSH = 2'd1, OP_FORCE = 2'd2, OP_STAGE = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] d;
    logic       ev;
    logic       en;
    logic [7:0] ed;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t TBL [NVEC] = '{
    '{OP_REQ,   8'h00, 1'b1, 1'b0, 8'h01},  // R1 reset staged byte
    '{OP_REQ,   8'h00, 1'b0, 1'b1, 8'h00},  // R5
    '{OP_PUSH,  8'h0A, 1'b0, 1'b0, 8'h00},
    '{OP_PUSH,  8'h3C, 1'b0, 1'b0, 8'h00},
    '{OP_FORCE, 8'hAA, 1'b0, 1'b0, 8'h00},
    '{OP_STAGE, 8'h55, 1'b0, 1'b0, 8'h00},
    '{OP_REQ,   8'h00, 1'b1, 1'b0, 8'h0A},  // R2
    '{OP_REQ,   8'h00, 1'b1, 1'b0, 8'h3C},  // R2 order
    '{OP_REQ,   8'h00, 1'b1, 1'b0, 8'hAA},  // R3
    '{OP_REQ,   8'h00, 1'b1, 1'b0, 8'h55},  // R4
    '{OP_REQ,   8'h00, 1'b0, 1'b1, 8'h00},  // R5
    '{OP_PUSH,  8'h11, 1'b0, 1'b0, 8'h00},
    '{OP_REQ,   8'h00, 1'b1, 1'b0, 8'h11},  // R2
    '{OP_REQ,   8'h00, 1'b0, 1'b1, 8'h00}   // R5
  };

  logic clk = 1'b0, rst = 1'b1;
  logic host_wr_en = 1'b0, force_arm = 1'b0, stage_load = 1'b0, eng_req = 1'b0, stat_clr = 1'b0;
  logic [7:0] host_wr_data = '0, force_data = '0, stage_data = '0;

  logic host_full, rply_valid, rply_none;
  logic [7:0] rply_data;
  logic [15:0] cnt_total, cnt_fifo, cnt_fallback, cnt_none, cnt_ovwr;
  logic [3:0] fifo_level;

  logic n_full, n_valid, n_none;
  logic [7:0] n_data;
  logic [2:0] n_total, n_fifo, n_fallback, n_cnone, n_ovwr;
  logic [2:0] n_level;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  reply_source_arbiter dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_full(host_full), .force_arm(force_arm), .force_data(force_data),
    .stage_load(stage_load), .stage_data(stage_data), .eng_req(eng_req),
    .rply_valid(rply_valid), .rply_none(rply_none), .rply_data(rply_data),
    .stat_clr(stat_clr), .cnt_total(cnt_total), .cnt_fifo(cnt_fifo),
    .cnt_fallback(cnt_fallback), .cnt_none(cnt_none), .cnt_ovwr(cnt_ovwr),
    .fifo_level(fifo_level)
  );

  reply_source_arbiter #(.DEPTH(4), .OVERWRITE(1'b0), .CNT_W(3)) dut_nov (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_full(n_full), .force_arm(force_arm), .force_data(force_data),
    .stage_load(stage_load), .stage_data(stage_data), .eng_req(eng_req),
    .rply_valid(n_valid), .rply_none(n_none), .rply_data(n_data),
    .stat_clr(stat_clr), .cnt_total(n_total), .cnt_fifo(n_fifo),
    .cnt_fallback(n_fallback), .cnt_none(n_cnone), .cnt_ovwr(n_ovwr),
    .fifo_level(n_level)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    host_wr_en = 1'b1; host_wr_data = d;
    tick();
    host_wr_en = 1'b0;
  endtask

  task automatic request();
    eng_req = 1'b1;
    tick();
    eng_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();

    // R1 reset state
    check("R1 valid", rply_valid, 0);
    check("R1 none", rply_none, 0);
    check("R1 level", fifo_level, 0);
    check("R1 full", host_full, 0);
    check("R1 counters", {cnt_total, cnt_fifo, cnt_fallback, cnt_none, cnt_ovwr}, 0);

    // Vector table: priority order and single-use sources
    for (int i = 0; i < NVEC; i++) begin
      case (TBL[i].op)
        OP_PUSH:  push(TBL[i].d);
        OP_FORCE: begin force_arm = 1'b1; force_data = TBL[i].d; tick(); force_arm = 1'b0; end
        OP_STAGE: begin stage_load = 1'b1; stage_data = TBL[i].d; tick(); stage_load = 1'b0; end
        default: begin
          request();
          check($sformatf("R2-5 vec%0d valid", i), rply_valid, TBL[i].ev);
          check($sformatf("R2-5 vec%0d none", i), rply_none, TBL[i].en);
          if (TBL[i].ev) check($sformatf("R2-5 vec%0d data", i), rply_data, TBL[i].ed);
        end
      endcase
    end

    // R9 counters after the table
    check("R9 total", cnt_total, 6);
    check("R9 fifo", cnt_fifo, 3);
    check("R9 fallback", cnt_fallback, 3);
    check("R9 none", cnt_none, 3);
    check("R9 ovwr", cnt_ovwr, 0);

    // R6 overwrite: 9 writes into a ring of 8
    for (int k = 0; k < 8; k++) push(8'h20 + 8'(k));
    check("R6 full", host_full, 1);
    check("R9 level", fifo_level, 8);
    push(8'h28);
    check("R6 ovwr count", cnt_ovwr, 1);
    check("R6 level stays", fifo_level, 8);
    for (int k = 0; k < 8; k++) begin
      request();
      check($sformatf("R6 drain%0d", k), rply_data, 32'(8'h21 + 8'(k)));
    end
    request();
    check("R6 empty after drain", rply_none, 1);

    // R8 same-cycle write and request on empty ring
    host_wr_en = 1'b1; host_wr_data = 8'h77; eng_req = 1'b1;
    tick();
    host_wr_en = 1'b0; eng_req = 1'b0;
    check("R8 no same-cycle reply", rply_none, 1);
    request();
    check("R8 next valid", rply_valid, 1);
    check("R8 next data", rply_data, 8'h77);

    // R7 refuse policy on the small instance
    for (int k = 0; k < 5; k++) push(8'h40 + 8'(k));
    check("R7 full", n_full, 1);
    check("R7 level", n_level, 4);
    check("R7 no overwrite", n_ovwr, 0);
    for (int k = 0; k < 4; k++) begin
      request();
      check($sformatf("R7 drain%0d", k), n_data, 32'(8'h40 + 8'(k)));
    end
    request();
    check("R7 refused byte absent", n_none, 1);
    check("R2 main fifth", rply_data, 8'h44);

    // R10 saturation on 3-bit counters
    for (int k = 0; k < 10; k++) request();
    check("R10 saturated", n_cnone, 7);
    stat_clr = 1'b1;
    tick();
    stat_clr = 1'b0;
    check("R10 clear small", n_cnone, 0);
    check("R10 clear main", {cnt_total, cnt_none, cnt_ovwr}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule